// File: doc/BRIEF.md
# Interrupt Aggregator with Keyed Soft Reset

This block gathers six single-cycle event pulses from a serial-peripheral engine into one level-sensitive interrupt line. Each pulse sets a sticky status bit. A per-source enable register masks the status bits, and their OR drives the output only while a separate global gate bit is set. Software acknowledges sources by writing ones to the status register. The usual handler reads the status word and writes the same word back.

A fourth register acts as a keyed soft reset. Writing one exact 32-bit value to it clears all interrupt state and raises a one-cycle reset pulse for the rest of the peripheral. Any other value written to it is ignored. The register port is a simple single-cycle write strobe with a combinational read data path.

Top module: `irq_agg_top`

## Requirements
- R1: After rst_ni is released, the status, enable and global-gate registers read 0, and irq_o and soft_rst_o are low.
- R2: The status register sits at offset 0x20. Its bits are: 0 mode fault, 1 slave mode fault, 2 transmit empty, 3 transmit underrun, 4 receive full, 5 receive overrun. A 1 on ev_i[k] at a clock edge sets status bit k from that edge on, whatever the enable state. Bits 31:6 read 0.
- R3: A write to offset 0x20 clears exactly the status bits that are 1 in wdata_i[5:0], from that edge on. Bits written as 0 keep their value.
- R4: If an event and a clearing write hit the same status bit at the same edge, the bit ends up set.
- R5: The enable register sits at offset 0x28. Bits 5:0 are stored and read back, bits 31:6 read 0. Writing 0 masks every source, so irq_o goes low.
- R6: The global gate is bit 31 of offset 0x1C. Only that bit is stored, and the other bits read 0. While it is 0, irq_o is low.
- R7: irq_o equals gate AND the OR over bits k of (status[k] AND enable[k]). It is computed from the registers, so it reflects a write or an event in the cycle after that edge.
- R8: A write of exactly 0x0000000A to offset 0x40 clears the status, enable and gate registers at that edge, and this clear overrides any event at the same edge. soft_rst_o is then high for exactly the following cycle.
- R9: Writes of any other value to offset 0x40 change no register and leave soft_rst_o low. Offset 0x40 reads 0.
- R10: Writes to unmapped offsets change nothing, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Write strobe, one write per cycle |
| addr_i | input | 8 | Register byte offset |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for addr_i, combinational |
| ev_i | input | 6 | Event pulses from the peripheral |
| irq_o | output | 1 | Combined interrupt request |
| soft_rst_o | output | 1 | One-cycle peripheral reset pulse |

## Verification
An event pulse and a status acknowledge write can arrive at the same edge and target the same bit. An event can also coincide with the soft-reset key write. Directed steps drive each of these pairs on purpose: a clear of all bits together with an event on transmit underrun, and the key write together with a full event vector. The random phase then mixes events on about a quarter of cycles with writes to every offset, so such collisions recur many times. A bench model applies the stated priorities, event over clear and key reset over event, and every register read and every cycle's irq_o and soft_rst_o are compared against that model.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum int unsigned {
    SRC_MODE_FLT = 0,
    SRC_SLV_FLT  = 1,
    SRC_TX_EMPTY = 2,
    SRC_TX_UNDR  = 3,
    SRC_RX_FULL  = 4,
    SRC_RX_OVR   = 5
  } src_e;

  localparam int unsigned N_SRC    = int'(SRC_RX_OVR) + 1;
  localparam int unsigned ADDR_W   = 8;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned GATE_BIT = 31;

  localparam logic [ADDR_W-1:0] OFS_GATE = 8'h1C;
  localparam logic [ADDR_W-1:0] OFS_STAT = 8'h20;
  localparam logic [ADDR_W-1:0] OFS_IEN  = 8'h28;
  localparam logic [ADDR_W-1:0] OFS_SRST = 8'h40;

  localparam logic [DATA_W-1:0] SRST_KEY = 32'h0000_000A;
endpackage

// File: rtl/irq_agg_status.sv
module irq_agg_status #(
  parameter int unsigned N_SRC = irq_agg_pkg::N_SRC
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_all_i,
  input  logic [N_SRC-1:0] ack_i,
  input  logic [N_SRC-1:0] ev_i,
  output logic [N_SRC-1:0] status_o
);
  logic [N_SRC-1:0] status_q;

  for (genvar g = 0; g < N_SRC; g++) begin : g_bit
    // soft reset > event > acknowledge
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            status_q[g] <= 1'b0;
      else if (clr_all_i)     status_q[g] <= 1'b0;
      else if (ev_i[g])       status_q[g] <= 1'b1;
      else if (ack_i[g])      status_q[g] <= 1'b0;
    end

    // R2
    ev_latch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_all_i && ev_i[g]) |=> status_q[g]);

    // R3
    ack_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!ev_i[g] && ack_i[g]) |=> !status_q[g]);

    // R4
    ev_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!clr_all_i && ev_i[g] && ack_i[g]) |=> status_q[g]);
  end

  assign status_o = status_q;
endmodule

// File: rtl/irq_agg_mask.sv
module irq_agg_mask #(
  parameter int unsigned N_SRC    = irq_agg_pkg::N_SRC,
  parameter int unsigned DATA_W   = irq_agg_pkg::DATA_W,
  parameter int unsigned GATE_BIT = irq_agg_pkg::GATE_BIT
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_all_i,
  input  logic              ien_we_i,
  input  logic              gate_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [N_SRC-1:0]  status_i,
  output logic [N_SRC-1:0]  ien_o,
  output logic              gate_o,
  output logic              irq_o
);
  logic [N_SRC-1:0] ien_q;
  logic             gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        ien_q <= '0;
    else if (clr_all_i) ien_q <= '0;
    else if (ien_we_i)  ien_q <= wdata_i[N_SRC-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gate_q <= 1'b0;
    else if (clr_all_i)  gate_q <= 1'b0;
    else if (gate_we_i)  gate_q <= wdata_i[GATE_BIT];
  end

  assign irq_o  = gate_q & (|(status_i & ien_q));
  assign ien_o  = ien_q;
  assign gate_o = gate_q;

  // R5
  ien_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien_we_i && wdata_i[N_SRC-1:0] == '0) |=> !irq_o);

  // R6
  gate_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_we_i && !wdata_i[GATE_BIT]) |=> !irq_o);

  // R7
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (status_i != '0));
endmodule

// File: rtl/irq_agg_srst.sv
module irq_agg_srst #(
  parameter int unsigned       DATA_W = irq_agg_pkg::DATA_W,
  parameter logic [DATA_W-1:0] KEY    = irq_agg_pkg::SRST_KEY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_sel_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic              hit_o,
  output logic              pulse_o
);
  logic pulse_q;

  assign hit_o = wr_sel_i && (wdata_i == KEY);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pulse_q <= 1'b0;
    else         pulse_q <= hit_o;
  end

  assign pulse_o = pulse_q;

  // R9
  bad_key_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i && wdata_i != KEY) |=> !pulse_o);

  // R8
  key_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_sel_i && wdata_i == KEY) |=> pulse_o);
endmodule

// File: rtl/irq_agg_top.sv
module irq_agg_top #(
  parameter int unsigned       N_SRC    = irq_agg_pkg::N_SRC,
  parameter int unsigned       ADDR_W   = irq_agg_pkg::ADDR_W,
  parameter int unsigned       DATA_W   = irq_agg_pkg::DATA_W,
  parameter int unsigned       GATE_BIT = irq_agg_pkg::GATE_BIT,
  parameter logic [ADDR_W-1:0] OFS_GATE = irq_agg_pkg::OFS_GATE,
  parameter logic [ADDR_W-1:0] OFS_STAT = irq_agg_pkg::OFS_STAT,
  parameter logic [ADDR_W-1:0] OFS_IEN  = irq_agg_pkg::OFS_IEN,
  parameter logic [ADDR_W-1:0] OFS_SRST = irq_agg_pkg::OFS_SRST,
  parameter logic [DATA_W-1:0] SRST_KEY = irq_agg_pkg::SRST_KEY
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic [N_SRC-1:0]  ev_i,
  output logic              irq_o,
  output logic              soft_rst_o
);
  localparam int unsigned PAD_W = DATA_W - N_SRC;

  logic             wr_gate, wr_stat, wr_ien, wr_srst;
  logic             srst_hit;
  logic [N_SRC-1:0] status, ien, ack;
  logic             gate;

  assign wr_gate = we_i && (addr_i == OFS_GATE);
  assign wr_stat = we_i && (addr_i == OFS_STAT);
  assign wr_ien  = we_i && (addr_i == OFS_IEN);
  assign wr_srst = we_i && (addr_i == OFS_SRST);
  assign ack     = wr_stat ? wdata_i[N_SRC-1:0] : '0;

  irq_agg_srst #(
    .DATA_W (DATA_W),
    .KEY    (SRST_KEY)
  ) u_srst (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_sel_i (wr_srst),
    .wdata_i  (wdata_i),
    .hit_o    (srst_hit),
    .pulse_o  (soft_rst_o)
  );

  irq_agg_status #(
    .N_SRC (N_SRC)
  ) u_status (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (srst_hit),
    .ack_i     (ack),
    .ev_i      (ev_i),
    .status_o  (status)
  );

  irq_agg_mask #(
    .N_SRC    (N_SRC),
    .DATA_W   (DATA_W),
    .GATE_BIT (GATE_BIT)
  ) u_mask (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_all_i (srst_hit),
    .ien_we_i  (wr_ien),
    .gate_we_i (wr_gate),
    .wdata_i   (wdata_i),
    .status_i  (status),
    .ien_o     (ien),
    .gate_o    (gate),
    .irq_o     (irq_o)
  );

  always_comb begin
    rdata_o = '0;
    if (addr_i == OFS_GATE)      rdata_o[GATE_BIT] = gate;
    else if (addr_i == OFS_STAT) rdata_o = {{PAD_W{1'b0}}, status};
    else if (addr_i == OFS_IEN)  rdata_o = {{PAD_W{1'b0}}, ien};
  end

  // R8
  srst_clean_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_o |-> (status == '0 && ien == '0 && !gate));

  // R10
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && !wr_gate && !wr_stat && !wr_ien && !wr_srst && ev_i == '0)
      |=> ($stable(status) && $stable(ien) && $stable(gate)));
endmodule

// File: tb/irq_agg_top_tb_top.sv
`timescale 1ns/1ps
module irq_agg_top_tb_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        we_i = 1'b0;
  logic [7:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic [5:0]  ev_i = '0;
  logic        irq_o;
  logic        soft_rst_o;

  int n_run = 0;
  int n_fail = 0;

  logic [5:0] m_st = '0, m_en = '0;
  logic       m_gate = 1'b0, m_rst = 1'b0;

  always #2.5 clk_i = ~clk_i;

  irq_agg_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .ev_i(ev_i),
    .irq_o(irq_o), .soft_rst_o(soft_rst_o)
  );

  function automatic logic m_irq();
    return m_gate & (|(m_st & m_en));
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    case (a)
      8'h1C:   return {m_gate, 31'b0};
      8'h20:   return {26'b0, m_st};
      8'h28:   return {26'b0, m_en};
      default: return 32'b0;
    endcase
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge(logic we, logic [7:0] a, logic [31:0] d, logic [5:0] ev);
    if (we && a == 8'h40 && d == 32'h0000_000A) begin
      m_st = '0; m_en = '0; m_gate = 1'b0; m_rst = 1'b1;
    end else begin
      m_rst = 1'b0;
      m_st = (m_st & ~((we && a == 8'h20) ? d[5:0] : 6'h0)) | ev;
      if (we && a == 8'h28) m_en = d[5:0];
      if (we && a == 8'h1C) m_gate = d[31];
    end
  endtask

  // one cycle: drive at negedge, check outputs 1 ns after the edge
  task automatic step(logic we, logic [7:0] a, logic [31:0] d, logic [5:0] ev,
                      logic do_rd = 1'b0, string tag = "");
    @(negedge clk_i);
    we_i = we; addr_i = a; wdata_i = d; ev_i = ev;
    #1;
    if (do_rd) chk(tag, rdata_o, m_read(a));
    @(posedge clk_i);
    model_edge(we, a, d, ev);
    #1;
    chk("R7 irq_o", {31'b0, irq_o}, {31'b0, m_irq()});
    chk("R8 soft_rst_o", {31'b0, soft_rst_o}, {31'b0, m_rst});
  endtask

  task automatic rd(logic [7:0] a, string tag);
    step(1'b0, a, 32'h0, 6'h0, 1'b1, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (3) @(posedge clk_i);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk("R1 irq_o", {31'b0, irq_o}, 32'h0);
    chk("R1 soft_rst_o", {31'b0, soft_rst_o}, 32'h0);
    rd(8'h1C, "R1 gate"); rd(8'h20, "R1 status"); rd(8'h28, "R1 enable");

    // R2 each source latches while masked
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 8'h00, 32'h0, 6'(1 << k));
      rd(8'h20, "R2 latch");
    end
    // R3 partial acknowledge
    step(1'b1, 8'h20, 32'hFFFF_FF05, 6'h0);
    rd(8'h20, "R3 ack");
    // R5/R6/R7 masking and gating
    step(1'b1, 8'h28, 32'hFFFF_FFFF, 6'h0);
    rd(8'h28, "R5 enable rb");
    step(1'b1, 8'h1C, 32'h7FFF_FFFF, 6'h0);
    rd(8'h1C, "R6 gate off rb");
    step(1'b1, 8'h1C, 32'h8000_0000, 6'h0);
    rd(8'h1C, "R6 gate on rb");
    step(1'b1, 8'h28, 32'h0, 6'h0);
    rd(8'h28, "R5 mask all");
    step(1'b1, 8'h28, 32'h0000_0008, 6'h0);
    // R4 event beats clear on same bit
    step(1'b1, 8'h20, 32'h0000_003F, 6'h08);
    rd(8'h20, "R4 event wins");
    // R9 wrong keys
    step(1'b1, 8'h40, 32'h0000_000B, 6'h0);
    step(1'b1, 8'h40, 32'h8000_000A, 6'h0);
    step(1'b1, 8'h40, 32'h0000_0000, 6'h0);
    rd(8'h40, "R9 srst reads 0");
    rd(8'h20, "R9 status kept");
    rd(8'h28, "R9 enable kept");
    // R10 unmapped
    step(1'b1, 8'h24, 32'hFFFF_FFFF, 6'h0);
    step(1'b1, 8'h2C, 32'hFFFF_FFFF, 6'h0);
    rd(8'h24, "R10 unmapped read");
    rd(8'h28, "R10 enable kept");
    rd(8'h1C, "R10 gate kept");
    // R8 key reset with concurrent events
    step(1'b1, 8'h40, 32'h0000_000A, 6'h3F);
    step(1'b0, 8'h00, 32'h0, 6'h0);
    rd(8'h20, "R8 status cleared");
    rd(8'h28, "R8 enable cleared");
    rd(8'h1C, "R8 gate cleared");

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [7:0]  a;
      logic [31:0] d;
      logic [5:0]  ev;
      logic        we;
      case ($urandom % 6)
        0: a = 8'h1C; 1, 2: a = 8'h20; 3: a = 8'h28;
        4: a = 8'h40; default: a = 8'h24;
      endcase
      d  = $urandom;
      if (a == 8'h40 && ($urandom % 8) != 0) d = 32'h0000_000A ^ (32'h1 << ($urandom % 32));
      if (a == 8'h40 && ($urandom % 16) == 0) d = 32'h0000_000A;
      if (a == 8'h1C && ($urandom % 2) == 0) d[31] = 1'b1;
      ev = (($urandom % 4) == 0) ? 6'($urandom) : 6'h0;
      we = ($urandom % 3) != 0;
      if (we) step(1'b1, a, d, ev);
      else    step(1'b0, a, 32'h0, ev, 1'b1, "R2 R5 R6 random read");
    end

    @(negedge clk_i);
    we_i = 1'b0; ev_i = '0;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule